// File: doc/BRIEF.md
# Divide-by-Twelve Two-Section Counter

This block is a four-bit counter built from two sections. The first section is a single toggle stage that halves its count input. The second section, fed from its own count input, first divides by three on a two-bit state and then halves that result. Every count input is sampled on the rising edge of a system clock, and a section advances when its input is seen high at one sample and low at the next.

A mode input either keeps the two sections apart or feeds the output of the first section into the second. In the chained mode, a pulse train on the first count input gives divide-by-two, divide-by-six and divide-by-twelve outputs. The top output is a square wave that stays high for six input pulses and low for six. Each chained stage reacts one clock after the stage that drives it, so the outputs change one after another. Any logic that decodes several outputs at once can therefore see short false states.

Top module: `div12_counter`

## Requirements
- R1: An active-low `rst_n` clears `q0`, `q1`, `q2` and `q3` to 0 at once, without waiting for a clock edge.
- R2: `q0` toggles at a rising clock edge exactly when `cnt0_in` is sampled 0 at that edge after being sampled 1 at the previous edge. Otherwise `q0` holds.
- R3: The pair `{q2,q1}` steps 00, 01, 10, then back to 00, one step for each second-section event. It never holds 11.
- R4: With `tie_en`=0, a second-section event is a high-to-low change of `cnt1_in`, seen the same way as in R2, and `{q2,q1}` updates at that same edge. `cnt0_in` has no effect on `q1`..`q3`, and `cnt1_in` has no effect on `q0`.
- R5: `q3` toggles at the clock edge after the edge where `q2` fell from 1 to 0. This makes `q3` a divide-by-six of the second-section events.
- R6: With `tie_en`=1, a second-section event occurs at the clock edge after `q0` falls from 1 to 0, and `cnt1_in` is ignored.
- R7: With `tie_en`=1, after n falling edges on `cnt0_in` following reset, the outputs settle to `q0` = n mod 2, `{q2,q1}` = (n/2) mod 3 and `q3` = (n/6) mod 2. `q3` is high for 6 of every 12 input pulses.
- R8: A high level or a rising transition on a count input never advances any section.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt0_in | input | 1 | Count input of the divide-by-two section |
| cnt1_in | input | 1 | Count input of the divide-by-six section (independent mode) |
| tie_en | input | 1 | 1 chains `q0` into the second section; 0 keeps the sections apart |
| q0 | output | 1 | Divide-by-two output |
| q1 | output | 1 | Low bit of the divide-by-three state |
| q2 | output | 1 | High bit of the divide-by-three state |
| q3 | output | 1 | Divide-by-six output (divide-by-twelve in chained mode) |

## Verification
The hardest case to reach is the full ripple in chained mode. There, a single falling input on `cnt0_in` must pass through `q0`, then wrap the divide-by-three state, and then toggle `q3`, one clock at a time. This happens only on every sixth input pulse from reset. The bench sweeps more than two full twelve-pulse periods. After each falling input it records the outputs at each of the next four clocks and compares each snapshot with the staged value it computes from the pulse count. It also runs mixed, overlapping pulse patterns on both inputs in independent mode, checks that outputs hold while the inputs are high, and applies reset in the middle of a run while the state is non-zero.

// File: rtl/div12_counter.sv
`timescale 1ns/1ps
module div12_counter (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt0_in,
  input  logic cnt1_in,
  input  logic tie_en,
  output logic q0,
  output logic q1,
  output logic q2,
  output logic q3
);
  logic cnt0_d, src_d, q2_d;
  logic src, fall0, fall1, fall_q2;

  assign src     = tie_en ? q0 : cnt1_in;
  assign fall0   = cnt0_d & ~cnt0_in;
  assign fall1   = src_d & ~src;
  assign fall_q2 = q2_d & ~q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt0_d <= 1'b0;
      src_d  <= 1'b0;
      q2_d   <= 1'b0;
      q0     <= 1'b0;
      q1     <= 1'b0;
      q2     <= 1'b0;
      q3     <= 1'b0;
    end else begin
      cnt0_d <= cnt0_in;
      src_d  <= src;
      q2_d   <= q2;
      if (fall0) q0 <= ~q0;
      if (fall1) {q2, q1} <= q2 ? 2'b00 : {q1, ~q1};
      if (fall_q2) q3 <= ~q3;
    end
  end
endmodule

module div12_counter_chk (
  input logic clk,
  input logic rst_n,
  input logic cnt0_in,
  input logic cnt1_in,
  input logic tie_en,
  input logic q0,
  input logic q1,
  input logic q2,
  input logic q3
);
  assert_no_state_11_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(q2 && q1));

  assert_q0_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q0 != $past(q0)) |-> ($past(cnt0_in, 2) && !$past(cnt0_in)));

  assert_step_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({q2, q1} != $past({q2, q1})) |->
      ({q2, q1} == (($past({q2, q1}) == 2'b10) ? 2'b00 : $past({q2, q1}) + 2'b01)));

  assert_indep_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tie_en && ({q2, q1} != $past({q2, q1}))) |-> ($past(cnt1_in, 2) && !$past(cnt1_in)));

  assert_q3_after_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q3 != $past(q3)) |-> ($past(q2, 2) && !$past(q2)));

  assert_tied_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tie_en && ({q2, q1} != $past({q2, q1}))) |-> ($past(q0, 2) && !$past(q0)));
endmodule

bind div12_counter div12_counter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cnt0_in(cnt0_in), .cnt1_in(cnt1_in), .tie_en(tie_en),
  .q0(q0), .q1(q1), .q2(q2), .q3(q3)
);

// File: tb/test_div12_counter.sv
`timescale 1ns/1ps
module test_div12_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt0_in = 1'b0;
  logic cnt1_in = 1'b0;
  logic tie_en = 1'b0;
  logic q0, q1, q2, q3;
  int checks = 0;
  int failures = 0;
  int n0, n1;
  logic [3:0] snap [1:4];

  always #2 clk = ~clk;

  div12_counter i_div12_counter (
    .clk(clk), .rst_n(rst_n), .cnt0_in(cnt0_in), .cnt1_in(cnt1_in), .tie_en(tie_en),
    .q0(q0), .q1(q1), .q2(q2), .q3(q3)
  );

  function automatic logic [3:0] expect_of(int a, int b);
    int s;
    s = b % 3;
    return {1'((b / 3) % 2), 1'(s >> 1), 1'(s & 1), 1'(a % 2)};
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b (q3q2q1q0)", tag, act, exp);
    end
  endtask

  task automatic pulse(logic a, logic b);
    logic [3:0] old_v, new_v;
    int m0, m1;
    m0 = n0 + (a ? 1 : 0);
    m1 = tie_en ? m0 / 2 : n1 + (b ? 1 : 0);
    old_v = tie_en ? expect_of(n0, n0 / 2) : expect_of(n0, n1);
    new_v = expect_of(m0, m1);
    @(negedge clk);
    cnt0_in = a;
    cnt1_in = b;
    repeat (2) @(negedge clk);
    chk("R8 high level holds", {q3, q2, q1, q0}, old_v);
    cnt0_in = 1'b0;
    cnt1_in = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      snap[k] = {q3, q2, q1, q0};
    end
    if (tie_en) begin
      chk("R6 ripple stage 1", snap[1], {old_v[3:1], new_v[0]});
      chk("R6 ripple stage 2", snap[2], {old_v[3], new_v[2:0]});
      chk("R5 ripple stage 3", snap[3], new_v);
      chk("R7 settled", snap[4], new_v);
    end else begin
      chk("R2 R4 first edge", snap[1], {old_v[3], new_v[2:0]});
      chk("R5 q3 next edge", snap[2], new_v);
      chk("R3 R4 settled", snap[4], new_v);
    end
    n0 = m0;
    n1 = m1;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    n0 = 0;
    n1 = 0;
    #1;
    chk("R1 reset state", {q3, q2, q1, q0}, 4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", {q3, q2, q1, q0}, 4'b0000);

    for (int i = 0; i < 30; i++)
      pulse(i % 3 != 1, i % 2 == 0 || i % 5 == 3);
    for (int i = 0; i < 8; i++) pulse(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);

    if ({q3, q2, q1, q0} == 4'b0000) pulse(1'b1, 1'b1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async clear", {q3, q2, q1, q0}, 4'b0000);
    tie_en = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n0 = 0;
    n1 = 0;
    repeat (2) @(negedge clk);
    chk("R1 tied start", {q3, q2, q1, q0}, 4'b0000);

    for (int i = 0; i < 30; i++) pulse(1'b1, i % 2 == 1);
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
    chk("R7 q3 after 30 pulses", {3'b000, q3}, {3'b000, 1'((30 / 6) % 2)});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule